// File: doc/BRIEF.md
# Single-Cycle Sequential Y86-Style Core

This block is a small 64-bit processor for a subset of a Y86-style instruction set. Each instruction is fetched, decoded, executed, written back and its successor address chosen within a single clock cycle. The subset covers halt, nop, immediate load, register move with its conditional variants, the four-function arithmetic/logic group, register-to-memory store and the unconditional jump. Memory is one byte-addressed array that holds both code and data. Fifteen 64-bit general registers and a two-flag condition register (sign and zero) make up the architectural state.

Program bytes go into memory through a byte write port while reset is held. Once reset is released the core runs from address zero. A debug view shows one chosen register and one chosen memory byte at any time. Control is a two-state machine. `ST_RUN` executes one instruction per clock. The transition `ST_RUN -> ST_HALT` is taken when the fetched instruction is halt or is not supported. `ST_HALT` holds every piece of state, and the only exit, `ST_HALT -> ST_RUN`, is reset.

Top module: `y86_seq_core`

## Requirements
- R1: After reset: the PC is 0, `halted` is 0, all fifteen registers read 0, the sign flag is 0, the zero flag is 1 and the state is `ST_RUN`.
- R2: Instruction encoding. Byte 0 holds the opcode in bits 7:4 and the function in bits 3:0. For register forms, byte 1 holds the source register rA in bits 7:4 and rB in bits 3:0. All multi-byte constants are little-endian. Opcodes and lengths: nop=1 (1 byte), move/conditional move=2 (2 bytes), OPq=6 (2 bytes), immediate load=3 (10 bytes), store=4 (10 bytes). The PC advances by the instruction length.
- R3: The immediate load (function 0) writes the 8-byte constant found at PC+2..PC+9 into rB.
- R4: OPq writes R[rB] OP R[rA] into rB. The function codes are 0 add, 1 subtract (rB minus rA), 2 and, 3 xor. It sets the zero flag to (result==0) and the sign flag to result bit 63. An OPq with a function code above 3 halts the core.
- R5: The flags change only when an OPq executes.
- R6: The move opcode copies R[rA] to rB when its condition holds. The conditions by function code are: 0 always, 1 SF or ZF, 2 SF, 3 ZF, 4 not ZF, 5 not SF, 6 neither SF nor ZF. A false condition writes nothing, and this check takes priority over normal destination selection. Function codes above 6 halt the core.
- R7: The store (function 0) computes its address as R[rB] plus the 8-byte displacement at PC+2..PC+9, modulo the memory size, using the ALU add. It writes R[rA] there as 8 little-endian bytes.
- R8: The jump (opcode 7, function 0, 9 bytes) loads the PC from the 8 bytes at PC+1..PC+8. A jump with a non-zero function halts the core.
- R9: Register code 0xF is "no register". As a destination it causes no write. As a source it reads 0.
- R10: Halt (opcode 0) or any unsupported opcode or function takes the core to `ST_HALT` with `halted`=1. The PC then points at that instruction, and PC, registers, flags and memory stay frozen until reset.
- R11: While `prog_we` is 1, `prog_byte` is written to `prog_addr` on the clock edge. `peek_reg_val` and `peek_byte` show the chosen register and memory byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_we | input | 1 | Program byte write enable |
| prog_addr | input | AW | Program byte address |
| prog_byte | input | 8 | Program byte data |
| peek_reg | input | 4 | Register selected for viewing |
| peek_reg_val | output | 64 | Value of the selected register (0 for code 0xF) |
| peek_addr | input | AW | Memory byte selected for viewing |
| peek_byte | output | 8 | Value of the selected memory byte |
| pc | output | 64 | Current program counter |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| halted | output | 1 | 1 while in `ST_HALT` |

## Verification
The embedded assertions check these properties every cycle:
- the halted state freezes the PC and the flags;
- the flags hold across any non-OPq cycle;
- OPq and store instructions advance the PC by their fixed lengths;
- a failed conditional move never enables a register write;
- the "no register" code reads as zero.

Arithmetic results, the little-endian byte order of immediates and stores, store address wrap-around, jump targets and the exact cycle of the halt transition depend on the program contents. The bench programs cover these by comparing every register, the PC and the flags against a behavioural instruction-level model after each clock.

// File: rtl/y86_pkg.sv
package y86_pkg;
    localparam int XLEN = 64;

    localparam logic [3:0] OPC_HALT  = 4'h0;
    localparam logic [3:0] OPC_NOP   = 4'h1;
    localparam logic [3:0] OPC_MOVE  = 4'h2;
    localparam logic [3:0] OPC_LDI   = 4'h3;
    localparam logic [3:0] OPC_STORE = 4'h4;
    localparam logic [3:0] OPC_ALU   = 4'h6;
    localparam logic [3:0] OPC_JUMP  = 4'h7;
    localparam logic [3:0] REG_NONE  = 4'hF;

    typedef enum logic {ST_RUN, ST_HALT} core_state_e;
    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_XOR} alu_op_e;

    function automatic logic cond_met(input logic [3:0] fn, input logic s, input logic z);
        case (fn)
            4'd0:    return 1'b1;
            4'd1:    return s | z;
            4'd2:    return s;
            4'd3:    return z;
            4'd4:    return ~z;
            4'd5:    return ~s;
            4'd6:    return ~s & ~z;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic can_execute(input logic [3:0] opc, input logic [3:0] fn);
        case (opc)
            OPC_NOP:                     return 1'b1;
            OPC_MOVE:                    return fn <= 4'd6;
            OPC_ALU:                     return fn <= 4'd3;
            OPC_LDI, OPC_STORE, OPC_JUMP: return fn == 4'd0;
            default:                     return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/y86_regfile.sv
module y86_regfile import y86_pkg::*; #(
    parameter int NREGS = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      rd_a_sel,
    output logic [XLEN-1:0] rd_a_val,
    input  logic [3:0]      rd_b_sel,
    output logic [XLEN-1:0] rd_b_val,
    input  logic [3:0]      view_sel,
    output logic [XLEN-1:0] view_val,
    input  logic            wr_en,
    input  logic [3:0]      wr_sel,
    input  logic [XLEN-1:0] wr_val
);
    logic [XLEN-1:0] bank [NREGS];

    assign rd_a_val = (int'(rd_a_sel) < NREGS) ? bank[rd_a_sel] : '0;
    assign rd_b_val = (int'(rd_b_sel) < NREGS) ? bank[rd_b_sel] : '0;
    assign view_val = (int'(view_sel) < NREGS) ? bank[view_sel] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) bank[i] <= '0;
        end else if (wr_en && int'(wr_sel) < NREGS) begin
            bank[wr_sel] <= wr_val;
        end
    end

    // R9: the empty register code always reads zero
    a_r9_none_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_a_sel == REG_NONE) |-> (rd_a_val == '0));
endmodule

// File: rtl/y86_mem.sv
module y86_mem import y86_pkg::*; #(
    parameter int MEM_BYTES   = 256,
    parameter int FETCH_BYTES = 10,
    localparam int AW         = $clog2(MEM_BYTES)
) (
    input  logic                     clk,
    input  logic [AW-1:0]            fetch_addr,
    output logic [FETCH_BYTES*8-1:0] fetch_win,
    input  logic                     st_en,
    input  logic [AW-1:0]            st_addr,
    input  logic [XLEN-1:0]          st_data,
    input  logic                     ld_en,
    input  logic [AW-1:0]            ld_addr,
    input  logic [7:0]               ld_byte,
    input  logic [AW-1:0]            view_addr,
    output logic [7:0]               view_byte
);
    localparam int WORD_BYTES = XLEN / 8;

    logic [7:0] cells [MEM_BYTES];

    for (genvar g = 0; g < FETCH_BYTES; g++) begin : g_fetch
        assign fetch_win[g*8 +: 8] = cells[fetch_addr + AW'(g)];
    end

    assign view_byte = cells[view_addr];

    always_ff @(posedge clk) begin
        if (st_en) begin
            for (int k = 0; k < WORD_BYTES; k++) cells[st_addr + AW'(k)] <= st_data[k*8 +: 8];
        end
        if (ld_en) cells[ld_addr] <= ld_byte;
    end
endmodule

// File: rtl/y86_alu.sv
module y86_alu import y86_pkg::*; (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic [XLEN-1:0] res,
    output logic            neg,
    output logic            zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: res = src_b + src_a;
            ALU_SUB: res = src_b - src_a;
            ALU_AND: res = src_b & src_a;
            ALU_XOR: res = src_b ^ src_a;
        endcase
    end
    assign neg  = res[XLEN-1];
    assign zero = (res == '0);
endmodule

// File: rtl/y86_seq_core.sv
module y86_seq_core import y86_pkg::*; #(
    parameter int MEM_BYTES = 256,
    localparam int AW       = $clog2(MEM_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_we,
    input  logic [AW-1:0]   prog_addr,
    input  logic [7:0]      prog_byte,
    input  logic [3:0]      peek_reg,
    output logic [XLEN-1:0] peek_reg_val,
    input  logic [AW-1:0]   peek_addr,
    output logic [7:0]      peek_byte,
    output logic [XLEN-1:0] pc,
    output logic            sf,
    output logic            zf,
    output logic            halted
);
    localparam int FETCH_BYTES = 10;
    localparam int NREGS       = 15;

    core_state_e     state, state_nx;
    logic [XLEN-1:0] pc_q, pc_nx;
    logic            sf_q, zf_q;

    logic [FETCH_BYTES*8-1:0] win;
    logic [3:0]      opc, fn, ra, rb, dst;
    logic [XLEN-1:0] imm_at2, imm_at1, ra_val, rb_val, alu_a, alu_res, wr_val;
    logic            alu_neg, alu_zero, running, exec_ok, move_ok;
    logic            rf_we, st_en, cc_we;
    alu_op_e         alu_op;

    assign opc     = win[7:4];
    assign fn      = win[3:0];
    assign ra      = win[15:12];
    assign rb      = win[11:8];
    assign imm_at1 = win[71:8];
    assign imm_at2 = win[79:16];

    assign running = (state == ST_RUN);
    assign exec_ok = can_execute(opc, fn);
    assign move_ok = cond_met(fn, sf_q, zf_q);

    y86_mem #(.MEM_BYTES(MEM_BYTES), .FETCH_BYTES(FETCH_BYTES)) u_mem (
        .clk(clk), .fetch_addr(pc_q[AW-1:0]), .fetch_win(win),
        .st_en(st_en), .st_addr(alu_res[AW-1:0]), .st_data(ra_val),
        .ld_en(prog_we), .ld_addr(prog_addr), .ld_byte(prog_byte),
        .view_addr(peek_addr), .view_byte(peek_byte)
    );

    y86_regfile #(.NREGS(NREGS)) u_rf (
        .clk(clk), .rst(rst),
        .rd_a_sel(ra), .rd_a_val(ra_val),
        .rd_b_sel(rb), .rd_b_val(rb_val),
        .view_sel(peek_reg), .view_val(peek_reg_val),
        .wr_en(rf_we), .wr_sel(dst), .wr_val(wr_val)
    );

    assign alu_op = (opc == OPC_ALU) ? alu_op_e'(fn[1:0]) : ALU_ADD;
    assign alu_a  = (opc == OPC_STORE) ? imm_at2 : ra_val;

    y86_alu u_alu (
        .op(alu_op), .src_a(alu_a), .src_b(rb_val),
        .res(alu_res), .neg(alu_neg), .zero(alu_zero)
    );

    // Destination selection: a failed conditional move is decided first
    always_comb begin
        dst    = REG_NONE;
        wr_val = alu_res;
        if (opc == OPC_MOVE && !move_ok) begin
            dst = REG_NONE;
        end else begin
            case (opc)
                OPC_MOVE: begin dst = rb; wr_val = ra_val;  end
                OPC_LDI:  begin dst = rb; wr_val = imm_at2; end
                OPC_ALU:  begin dst = rb; wr_val = alu_res; end
                default:  dst = REG_NONE;
            endcase
        end
    end

    assign rf_we = running && exec_ok && (dst != REG_NONE);
    assign st_en = running && exec_ok && (opc == OPC_STORE);
    assign cc_we = running && exec_ok && (opc == OPC_ALU);

    always_comb begin
        case (opc)
            OPC_NOP:            pc_nx = pc_q + 64'd1;
            OPC_MOVE, OPC_ALU:  pc_nx = pc_q + 64'd2;
            OPC_LDI, OPC_STORE: pc_nx = pc_q + 64'd10;
            OPC_JUMP:           pc_nx = imm_at1;
            default:            pc_nx = pc_q;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (!exec_ok) state_nx = ST_HALT;
            ST_HALT: state_nx = ST_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    // Architectural registers updated by the running state
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            sf_q <= 1'b0;
            zf_q <= 1'b1;
        end else if (running && exec_ok) begin
            pc_q <= pc_nx;
            if (cc_we) begin
                sf_q <= alu_neg;
                zf_q <= alu_zero;
            end
        end
    end

    assign pc     = pc_q;
    assign sf     = sf_q;
    assign zf     = zf_q;
    assign halted = (state == ST_HALT);

    a_r10_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_q) && $stable(sf_q) && $stable(zf_q)));

    a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !cc_we |=> ($stable(sf_q) && $stable(zf_q)));

    a_r2_alu_length: assert property (@(posedge clk) disable iff (rst)
        (running && exec_ok && opc == OPC_ALU) |=> (pc_q == $past(pc_q) + 64'd2));

    a_r7_store_length: assert property (@(posedge clk) disable iff (rst)
        st_en |=> (pc_q == $past(pc_q) + 64'd10));

    a_r6_false_move_silent: assert property (@(posedge clk) disable iff (rst)
        (running && opc == OPC_MOVE && !move_ok) |-> !rf_we);
endmodule

// File: tb/y86_seq_core_test.sv
`timescale 1ns/1ps
module y86_seq_core_test;
    localparam int MB = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [7:0]  prog_addr = '0;
    logic [7:0]  prog_byte = '0;
    logic [3:0]  peek_reg = '0;
    logic [63:0] peek_reg_val;
    logic [7:0]  peek_addr = '0;
    logic [7:0]  peek_byte;
    logic [63:0] pc;
    logic        sf, zf, halted;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    y86_seq_core uut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr), .prog_byte(prog_byte),
        .peek_reg(peek_reg), .peek_reg_val(peek_reg_val), .peek_addr(peek_addr),
        .peek_byte(peek_byte), .pc(pc), .sf(sf), .zf(zf), .halted(halted)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cycles++;

    // Behavioural reference model
    logic [7:0]  m_mem [MB];
    logic [63:0] m_reg [15];
    logic [63:0] m_pc;
    logic        m_sf, m_zf, m_halt;
    logic [7:0]  code [$];

    function automatic logic [7:0] mb(longint unsigned a);
        return m_mem[a % MB];
    endfunction

    function automatic logic [63:0] le8(longint unsigned a);
        logic [63:0] v = '0;
        for (int i = 7; i >= 0; i--) v = (v << 8) | 64'(mb(a + i));
        return v;
    endfunction

    function automatic logic [63:0] rget(logic [3:0] r);
        return (r == 4'hF) ? 64'd0 : m_reg[r];
    endfunction

    task automatic rset(logic [3:0] r, logic [63:0] v);
        if (r != 4'hF) m_reg[r] = v;
    endtask

    task automatic model_step();
        logic [3:0] ic, fnc, ra, rb;
        logic [63:0] a, b, res, addr;
        bit take;
        if (m_halt) return;
        ic = mb(m_pc) >> 4; fnc = mb(m_pc) & 8'h0F;
        ra = mb(m_pc + 1) >> 4; rb = mb(m_pc + 1) & 8'h0F;
        a = rget(ra); b = rget(rb);
        case (ic)
            1: m_pc += 1;
            2: begin
                case (fnc)
                    0: take = 1; 1: take = m_sf || m_zf; 2: take = m_sf; 3: take = m_zf;
                    4: take = !m_zf; 5: take = !m_sf; 6: take = !m_sf && !m_zf;
                    default: begin m_halt = 1; return; end
                endcase
                if (take) rset(rb, a);
                m_pc += 2;
            end
            3: begin
                if (fnc != 0) begin m_halt = 1; return; end
                rset(rb, le8(m_pc + 2)); m_pc += 10;
            end
            4: begin
                if (fnc != 0) begin m_halt = 1; return; end
                addr = b + le8(m_pc + 2);
                for (int i = 0; i < 8; i++) m_mem[(addr + i) % MB] = a[8*i +: 8];
                m_pc += 10;
            end
            6: begin
                case (fnc)
                    0: res = b + a; 1: res = b - a; 2: res = b & a; 3: res = b ^ a;
                    default: begin m_halt = 1; return; end
                endcase
                rset(rb, res); m_sf = res[63]; m_zf = (res == 0); m_pc += 2;
            end
            7: begin
                if (fnc != 0) begin m_halt = 1; return; end
                m_pc = le8(m_pc + 1);
            end
            default: m_halt = 1;
        endcase
    endtask

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Assembler helpers
    task automatic put8(logic [63:0] v);
        for (int i = 0; i < 8; i++) code.push_back(v[8*i +: 8]);
    endtask
    task automatic a_ldi(logic [3:0] rb, logic [63:0] v);
        code.push_back(8'h30); code.push_back({4'hF, rb}); put8(v);
    endtask
    task automatic a_op(logic [3:0] f, logic [3:0] ra, logic [3:0] rb);
        code.push_back({4'h6, f}); code.push_back({ra, rb});
    endtask
    task automatic a_mv(logic [3:0] f, logic [3:0] ra, logic [3:0] rb);
        code.push_back({4'h2, f}); code.push_back({ra, rb});
    endtask
    task automatic a_st(logic [3:0] ra, logic [3:0] rb, logic [63:0] d);
        code.push_back(8'h40); code.push_back({ra, rb}); put8(d);
    endtask
    task automatic a_jmp(logic [63:0] t);
        code.push_back(8'h70); put8(t);
    endtask

    // Compare all visible state against the model (called just after a falling edge)
    task automatic compare_all(string req);
        check("R2", "pc", pc, m_pc);
        check("R10", "halted", 64'(halted), 64'(m_halt));
        check({req, "/R5"}, "sf", 64'(sf), 64'(m_sf));
        check({req, "/R5"}, "zf", 64'(zf), 64'(m_zf));
        for (int r = 0; r < 15; r++) begin
            peek_reg = 4'(r);
            #0.1;
            check(req, $sformatf("reg%0d", r), peek_reg_val, m_reg[r]);
        end
    endtask

    task automatic load_and_run(int max_cycles, string req);
        rst = 1'b1;
        for (int i = 0; i < MB; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 8'(i);
            prog_byte = (i < code.size()) ? code[i] : 8'h00;
            m_mem[i] = prog_byte;
        end
        @(negedge clk);
        prog_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 15; r++) m_reg[r] = '0;
        m_pc = '0; m_sf = 1'b0; m_zf = 1'b1; m_halt = 1'b0;
        // R1: reset state
        check("R1", "reset pc", pc, 64'd0);
        check("R1", "reset halted", 64'(halted), 64'd0);
        check("R1", "reset sf", 64'(sf), 64'd0);
        check("R1", "reset zf", 64'(zf), 64'd1);
        for (int r = 0; r < 15; r++) begin
            peek_reg = 4'(r); #0.1;
            check("R1", $sformatf("reset reg%0d", r), peek_reg_val, 64'd0);
        end
        for (int c = 0; c < max_cycles; c++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare_all(req);
        end
    endtask

    function automatic logic [63:0] view(logic [3:0] r);
        return 64'(r);
    endfunction

    task automatic reg_is(string req, logic [3:0] r, logic [63:0] exp);
        peek_reg = r; #0.1;
        check(req, $sformatf("final reg%0d", r), peek_reg_val, exp);
    endtask

    task automatic mem_is(string req, logic [7:0] a, logic [7:0] exp);
        peek_addr = a; #0.1;
        check(req, $sformatf("mem[%h]", a), 64'(peek_byte), 64'(exp));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        // Program A: arithmetic group (R4, R3, R2)
        code.delete();
        a_ldi(4'd2, 64'd7); a_ldi(4'd1, 64'd3);
        a_op(4'd0, 4'd1, 4'd3); a_op(4'd1, 4'd2, 4'd1);
        a_op(4'd2, 4'd2, 4'd3); a_op(4'd3, 4'd1, 4'd2);
        a_op(4'd2, 4'd2, 4'd6); code.push_back(8'h00);
        load_and_run(12, "R4");
        reg_is("R4", 4'd1, 64'hffff_ffff_ffff_fffc);   // R4 subtract
        reg_is("R4", 4'd2, 64'hffff_ffff_ffff_fffb);   // R4 xor
        reg_is("R4", 4'd3, 64'd3);                     // R4 add then and
        reg_is("R3", 4'd6, 64'd0);
        check("R4", "final zf", 64'(zf), 64'd1);
        check("R10", "halt pc", pc, 64'd30);

        // Program B: conditional moves and the empty register code (R6, R9, R5)
        code.delete();
        a_ldi(4'd3, 64'hace); a_ldi(4'd0, 64'd1); a_op(4'd2, 4'd0, 4'd0);
        a_mv(4'd6, 4'd3, 4'd1); a_mv(4'd3, 4'd3, 4'd2);
        a_ldi(4'd0, 64'hffff_ffff_ffff_ffff); a_op(4'd2, 4'd0, 4'd0);
        a_mv(4'd2, 4'd3, 4'd4); a_mv(4'd5, 4'd3, 4'd5);
        a_op(4'd3, 4'd0, 4'd0);
        a_mv(4'd3, 4'd3, 4'd6); a_mv(4'd4, 4'd3, 4'd7); a_mv(4'd1, 4'd3, 4'd8);
        a_mv(4'd0, 4'd3, 4'd9); a_ldi(4'd10, 64'd5); a_mv(4'd0, 4'hF, 4'd10);
        a_mv(4'd0, 4'd3, 4'hF); code.push_back(8'h10); code.push_back(8'h00);
        load_and_run(22, "R6");
        reg_is("R6", 4'd1, 64'hace); reg_is("R6", 4'd2, 64'd0);
        reg_is("R6", 4'd4, 64'hace); reg_is("R6", 4'd5, 64'd0);
        reg_is("R6", 4'd6, 64'hace); reg_is("R6", 4'd7, 64'd0);
        reg_is("R6", 4'd8, 64'hace); reg_is("R6", 4'd9, 64'hace);
        reg_is("R9", 4'd10, 64'd0);    // source 0xF reads zero
        reg_is("R9", 4'hF, 64'd0);

        // Program C: stores, jump, frozen halt (R7, R8, R10, R11)
        code.delete();
        a_ldi(4'd0, 64'd2); a_ldi(4'd3, 64'd8); a_st(4'd3, 4'd0, 64'd160);
        a_ldi(4'd1, 64'h1122_3344_5566_7788); a_st(4'd1, 4'hF, 64'h10);
        a_jmp(64'd60); code.push_back(8'hC0);
        a_ldi(4'd11, 64'h77); a_st(4'd1, 4'd11, 64'h85); // 0x77+0x85 = 0xFC, wraps
        code.push_back(8'h00);
        load_and_run(16, "R7");
        mem_is("R7", 8'hA2, 8'h08); mem_is("R7", 8'hA3, 8'h00);
        mem_is("R7", 8'h10, 8'h88); mem_is("R7", 8'h17, 8'h11);
        mem_is("R7", 8'hFF, 8'h55); mem_is("R7", 8'h00, 8'h44);
        reg_is("R8", 4'd11, 64'h77);
        check("R8", "pc at halt", pc, 64'd80);
        for (int a = 0; a < MB; a++) begin
            peek_addr = 8'(a); #0.01;
            check("R11", "mem image", 64'(peek_byte), 64'(m_mem[a]));
        end
        repeat (3) @(negedge clk);
        check("R10", "frozen pc", pc, 64'd80);
        check("R10", "still halted", 64'(halted), 64'd1);

        // Program D: unsupported encodings halt (R10, R4)
        code.delete();
        a_ldi(4'd0, 64'd1); a_op(4'd0, 4'd0, 4'd0); code.push_back(8'h64); code.push_back(8'h00);
        load_and_run(5, "R10");
        check("R4", "bad alu fn pc", pc, 64'd12);
        reg_is("R4", 4'd0, 64'd2);
        code.delete();
        code.push_back(8'h10); code.push_back(8'h50);
        load_and_run(4, "R10");
        check("R10", "bad opcode pc", pc, 64'd1);
        check("R10", "bad opcode halted", 64'(halted), 64'd1);

        finish_run();
    end

    initial begin
        wait (cycles >= 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        finish_run();
    end
endmodule